// File: doc/BRIEF.md
# External Clock Failure Supervisor

This block guards a device whose system clock may come from an external input clock. While that external clock is the selected source, the supervisor measures it against a reference timebase taken from an independent internal oscillator. If the clock runs too slowly for too long, or stops altogether, the block issues a hardware reset request.

The measurement counts rising edges of the monitored clock inside fixed windows of reference cycles. A window whose count falls short of the count a 500 kHz clock would give is marked slow. A persistence counter adds up consecutive slow windows. Once the slow time exceeds 1 ms, it fires a reset pulse of fixed length. All measurement state clears whenever the enable is low, so a change of clock source never leaves stale progress behind.

The reference frequency, frequency floor, window length, persistence time and pulse length are all parameters. The enable and the reset output are plain level and pulse signals with no handshake.

Top module: `clk_fail_supervisor`

## Requirements
- R1: After `ref_rst_n` is released, `fail_rst` is low.
- R2: While `sup_en` is low, `fail_rst` never rises, whatever `mon_clk` does.
- R3: Each window is WIN_CYC reference cycles long. A window counts as slow when it sees fewer than MIN_EDGES = FLOOR_HZ*WIN_CYC/REF_HZ rising edges of `mon_clk`. A clock at exactly the floor frequency is not slow.
- R4: `fail_rst` rises only after LIMIT+1 consecutive slow windows, where LIMIT = ceil(PERSIST_US*REF_HZ/10^6 / WIN_CYC). It does not rise after LIMIT or fewer.
- R5: A monitored clock with no edges at all counts as slow in every window and leads to a reset.
- R6: Any window that is not slow clears the persistence count. The full run of LIMIT+1 slow windows must then start again.
- R7: When `sup_en` falls, all window and persistence progress is discarded. After re-enable, the full persistence time is needed again.
- R8: A reset request drives `fail_rst` high for exactly PULSE_CYC consecutive reference cycles.
- R9: A monitored clock well above the floor never causes `fail_rst` to rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock from the independent internal oscillator |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| mon_clk | input | 1 | External clock under supervision (asynchronous) |
| sup_en | input | 1 | High while the external clock is the selected source; synchronous to `ref_clk` |
| fail_rst | output | 1 | Active-high hardware reset request pulse |

## Verification
The assertions assume that `sup_en` changes synchronously to `ref_clk`. They also assume that `mon_clk` runs at less than half the reference rate, so each monitored rising edge is seen as exactly one single-cycle pulse after the synchronizer. The bench changes `sup_en` only on falling reference edges. It never drives `mon_clk` faster than 1 MHz against the 100 MHz reference, and it stops the clock by holding it low. Reset timing is checked against windows that open when the enable is applied.

// File: rtl/clk_sup_pkg.sv
package clk_sup_pkg;

  // Edges a clock at the floor frequency gives in one window.
  function automatic int floor_edges(longint ref_hz, longint floor_hz, longint win_cyc);
    longint e;
    e = (floor_hz * win_cyc) / ref_hz;
    return (e < 1) ? 1 : int'(e);
  endfunction

  // Number of windows that together span the persistence time (rounded up).
  function automatic int persist_windows(longint ref_hz, longint persist_us, longint win_cyc);
    longint cyc;
    longint w;
    cyc = (persist_us * ref_hz) / 64'd1_000_000;
    w   = (cyc + win_cyc - 1) / win_cyc;
    return (w < 1) ? 1 : int'(w);
  endfunction

endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_in};
  end

  assign rise = sh[1] & ~sh[2];

  // R3: each monitored edge yields a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cs_window_meter.sv
module cs_window_meter #(
  parameter int WIN_CYC   = 1000,
  parameter int MIN_EDGES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  output logic win_done,
  output logic win_slow
);
  localparam int CW  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int ECW = $clog2(MIN_EDGES + 1);

  logic [CW-1:0]  cyc;
  logic [ECW-1:0] ecnt, ecnt_inc;

  always_comb begin
    if (rise && (ecnt != ECW'(MIN_EDGES))) ecnt_inc = ecnt + 1'b1;
    else                                  ecnt_inc = ecnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0; ecnt <= '0; win_done <= 1'b0; win_slow <= 1'b0;
    end else if (!en) begin
      cyc <= '0; ecnt <= '0; win_done <= 1'b0; win_slow <= 1'b0;
    end else begin
      win_done <= 1'b0;
      if (cyc == CW'(WIN_CYC - 1)) begin
        cyc      <= '0;
        ecnt     <= '0;
        win_done <= 1'b1;
        win_slow <= (ecnt_inc < ECW'(MIN_EDGES));
      end else begin
        cyc  <= cyc + 1'b1;
        ecnt <= ecnt_inc;
      end
    end
  end

  // R7: disabling clears window progress on the next cycle
  a_r7_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cyc == '0 && ecnt == '0 && !win_done));
  // R3: window results are single-cycle events
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);
endmodule

// File: rtl/cs_persist.sv
module cs_persist #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic win_done,
  input  logic win_slow,
  output logic fire
);
  localparam int PW = $clog2(LIMIT + 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; fire <= 1'b0;
    end else if (!en) begin
      cnt <= '0; fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (win_done) begin
        if (!win_slow)                cnt <= '0;
        else if (cnt == PW'(LIMIT)) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else                      cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: slow-window count never passes the limit
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PW'(LIMIT));
  // R6: a window that is not slow restarts persistence
  a_r6_fast_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && win_done && !win_slow) |=> (cnt == '0 && !fire));
  // R2: no request while supervision is off
  a_r2_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fire);
endmodule

// File: rtl/cs_pulse_gen.sv
module cs_pulse_gen #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_o
);
  localparam int QW = $clog2(PULSE_CYC + 1);

  logic [QW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       left <= '0;
    else if (fire && left == '0)      left <= QW'(PULSE_CYC);
    else if (left != '0)              left <= left - 1'b1;
  end

  assign rst_o = (left != '0);

  // R8: the pulse only begins right after a request
  a_r8_rise_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(fire));
endmodule

// File: rtl/clk_fail_supervisor.sv
module clk_fail_supervisor #(
  parameter longint REF_HZ     = 100_000_000,
  parameter longint FLOOR_HZ   = 500_000,
  parameter longint PERSIST_US = 1000,
  parameter int     WIN_CYC    = 1000,
  parameter int     PULSE_CYC  = 16
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_clk,
  input  logic sup_en,
  output logic fail_rst
);
  import clk_sup_pkg::*;

  localparam int MIN_EDGES = floor_edges(REF_HZ, FLOOR_HZ, longint'(WIN_CYC));
  localparam int LIMIT     = persist_windows(REF_HZ, PERSIST_US, longint'(WIN_CYC));

  logic rise, win_done, win_slow, fire;

  cs_edge_sync u_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .async_in(mon_clk), .rise(rise)
  );

  cs_window_meter #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk(ref_clk), .rst_n(ref_rst_n), .en(sup_en), .rise(rise),
    .win_done(win_done), .win_slow(win_slow)
  );

  cs_persist #(.LIMIT(LIMIT)) u_persist (
    .clk(ref_clk), .rst_n(ref_rst_n), .en(sup_en),
    .win_done(win_done), .win_slow(win_slow), .fire(fire)
  );

  cs_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(ref_clk), .rst_n(ref_rst_n), .fire(fire), .rst_o(fail_rst)
  );

  // R1: output quiet straight after reset release
  a_r1_quiet_after_reset: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(ref_rst_n) |-> !fail_rst);
endmodule

// File: tb/clk_fail_supervisor_test.sv
module clk_fail_supervisor_test;
  localparam int WIN   = 400;
  localparam int PULSE = 16;
  // 500 kHz over 4 us of 100 MHz gives 2 edges; 20 us / 4 us gives 5 windows
  localparam int LIMIT = 5;
  localparam int FIRE_AT = (LIMIT + 1) * WIN;

  logic ref_clk = 1'b0;
  logic ref_rst_n = 1'b0;
  logic mon_clk = 1'b0;
  logic sup_en = 1'b0;
  logic fail_rst;
  int   mon_half = 0;   // half period in ns, 0 = stopped
  int   n_checks = 0;
  int   n_errors = 0;

  clk_fail_supervisor #(
    .REF_HZ(100_000_000), .FLOOR_HZ(500_000), .PERSIST_US(20),
    .WIN_CYC(WIN), .PULSE_CYC(PULSE)
  ) uut (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .mon_clk(mon_clk),
    .sup_en(sup_en), .fail_rst(fail_rst)
  );

  always #5 ref_clk = ~ref_clk;

  always begin
    if (mon_half == 0) begin
      mon_clk = 1'b0;
      #7;
    end else begin
      #(mon_half) mon_clk = ~mon_clk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // Counts cycles with fail_rst high over n cycles
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      if (fail_rst) hi++;
    end
  endtask

  // Waits up to n cycles for fail_rst, returns cycles waited (-1 if none)
  task automatic wait_rise(input int n, output int waited);
    waited = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      if (fail_rst) begin
        waited = i;
        break;
      end
    end
  endtask

  task automatic settle();
    @(negedge ref_clk);
    sup_en = 1'b0;
    mon_half = 0;
    cycles(40);
  endtask

  task automatic t_reset();
    cycles(3);
    check(fail_rst == 1'b0, "R1 reset state", fail_rst, 0);
  endtask

  task automatic t_stopped();
    int hi, w;
    mon_half = 0;
    @(negedge ref_clk); sup_en = 1'b1;
    count_high(FIRE_AT - 60, hi);
    check(hi == 0, "R4 no early reset on stopped clock", hi, 0);
    wait_rise(200, w);
    check(w >= 0, "R5 stopped clock triggers reset", w, 1);
    count_high(PULSE + 20, hi);
    check(hi == PULSE - 1, "R8 pulse width", hi + 1, PULSE);
    settle();
  endtask

  task automatic t_disabled();
    int hi;
    mon_half = 0;
    sup_en = 1'b0;
    count_high(3 * FIRE_AT, hi);
    check(hi == 0, "R2 disabled stopped clock", hi, 0);
    mon_half = 2000;
    count_high(FIRE_AT, hi);
    check(hi == 0, "R2 disabled slow clock", hi, 0);
    settle();
  endtask

  task automatic t_fast();
    int hi;
    mon_half = 500;     // 1 MHz
    @(negedge ref_clk); sup_en = 1'b1;
    count_high(4 * FIRE_AT, hi);
    check(hi == 0, "R9 fast clock never resets", hi, 0);
    settle();
  endtask

  task automatic t_at_floor();
    int hi;
    mon_half = 1000;    // exactly 500 kHz
    @(negedge ref_clk); sup_en = 1'b1;
    count_high(3 * FIRE_AT, hi);
    check(hi == 0, "R3 clock at floor is not slow", hi, 0);
    settle();
  endtask

  task automatic t_slow();
    int hi, w;
    mon_half = 2000;    // 250 kHz, one edge per window
    @(negedge ref_clk); sup_en = 1'b1;
    count_high(FIRE_AT - 60, hi);
    check(hi == 0, "R4 slow clock no early reset", hi, 0);
    wait_rise(200, w);
    check(w >= 0, "R3 slow clock counted as slow", w, 1);
    settle();
  endtask

  task automatic t_disable_clears();
    int hi, w;
    mon_half = 0;
    @(negedge ref_clk); sup_en = 1'b1;
    cycles(LIMIT * WIN + 200);
    sup_en = 1'b0;
    cycles(20);
    sup_en = 1'b1;
    count_high(FIRE_AT - 60, hi);
    check(hi == 0, "R7 progress cleared by disable", hi, 0);
    wait_rise(200, w);
    check(w >= 0, "R7 full time after re-enable", w, 1);
    settle();
  endtask

  task automatic t_fast_restarts();
    int hi, w;
    mon_half = 0;
    @(negedge ref_clk); sup_en = 1'b1;
    cycles(LIMIT * WIN - 200);
    mon_half = 500;
    cycles(1000);
    mon_half = 0;
    count_high(FIRE_AT - 60, hi);
    check(hi == 0, "R6 fast window restarts count", hi, 0);
    wait_rise(WIN + 300, w);
    check(w >= 0, "R6 reset after fresh run", w, 1);
    settle();
  endtask

  initial begin
    cycles(4);
    ref_rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_disabled();
    t_fast();
    t_at_floor();
    t_slow();
    t_disable_clears();
    t_fast_restarts();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule